// File: doc/BRIEF.md
# Burst Address Sequencer with Command Tracking

This block is the control front end of a synchronous burst memory. On every clock edge where the clock enable is active, it sorts the incoming control inputs into one of four commands. A command is a read that starts a burst, a write that starts a burst, a deselect, or a burst continue. From the command and its own state it steps a five-state controller:

| State | Code | Meaning |
|---|---|---|
| `ST_IDLE` | 0 | deselected |
| `ST_RD_NEW` | 1 | first beat of a read |
| `ST_WR_NEW` | 2 | first beat of a write |
| `ST_RD_BURST` | 3 | later read beats |
| `ST_WR_BURST` | 4 | later write beats |

The named transitions are:

- **load-read**: any state goes to `ST_RD_NEW`.
- **load-write**: any state goes to `ST_WR_NEW`.
- **drop**: any state goes to `ST_IDLE`.
- **stay-idle**: a continue in `ST_IDLE` keeps `ST_IDLE`.
- **extend-read**: a continue moves `ST_RD_NEW` or `ST_RD_BURST` to `ST_RD_BURST`.
- **extend-write**: a continue moves `ST_WR_NEW` or `ST_WR_BURST` to `ST_WR_BURST`.
- **freeze**: with the clock enable inactive, nothing changes.

The block also produces the two low address bits of a four-beat burst. It latches a start value from the external low address bits whenever a new address is loaded. It counts the beats that follow. It combines start and count in either linear or interleaved order, as selected by a static mode input. Downstream, the array uses the state to tell reads from writes and uses `acc_valid` to gate accesses.

Top module: `burst_seq`

## Requirements
- R1: After reset the state is `ST_IDLE` (0), the start value and beat count are zero, `addr_lo` is 0 and `acc_valid` is low.
- R2: On an enabled edge with `adv_ld` low, the next state depends on the other inputs:
  - `sel` low gives `ST_IDLE` (0).
  - `sel` high with `we_n` low gives `ST_WR_NEW` (2).
  - `sel` high with `we_n` high gives `ST_RD_NEW` (1).
- R3: On an enabled edge with `adv_ld` high, `ST_RD_NEW`/`ST_RD_BURST` go to `ST_RD_BURST` (3) and `ST_WR_NEW`/`ST_WR_BURST` go to `ST_WR_BURST` (4). The values of `we_n` and `sel` do not affect this.
- R4: A continue while in `ST_IDLE` leaves the state at `ST_IDLE`.
- R5: After an enabled load edge (`adv_ld` low, any command), `addr_lo` equals the `ext_addr_lo` value sampled at that edge.
- R6: Every enabled continue edge advances the beat count by one, wrapping from 3 to 0. This holds in every state, including `ST_IDLE`.
- R7: With `lin_n` low, `addr_lo` is (start + count) mod 4.
- R8: With `lin_n` high, `addr_lo` is start XOR count.
- R9: With `clk_en_n` high, the state, start value and count keep their values whatever the other inputs do.
- R10: `acc_valid` is high in every state except `ST_IDLE`, where it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | asynchronous reset, active low |
| clk_en_n | input | 1 | clock enable, active low; high freezes the block |
| adv_ld | input | 1 | low loads a new address and command, high continues the burst |
| we_n | input | 1 | write select on a load, active low |
| sel | input | 1 | combined chip select, active high |
| lin_n | input | 1 | burst order: low linear, high interleaved |
| ext_addr_lo | input | 2 | low bits of the external address |
| state | output | 3 | controller state code (0..4) |
| addr_lo | output | 2 | effective low address bits for the current beat |
| acc_valid | output | 1 | high when the current cycle is a memory access |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge once reset is released. They also treat `lin_n` as a level that may change only between cycles, because `addr_lo` follows it without a register. The bench drives every input at the falling edge, away from the sampling edge. It never leaves an input undriven. It compares `state`, `addr_lo` and `acc_valid` with a behavioural model at every falling edge. The stimulus mixes directed bursts in both orders, frozen cycles, and continues from the deselected state with a long random run.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_NEW   = 3'd1,
        ST_WR_NEW   = 3'd2,
        ST_RD_BURST = 3'd3,
        ST_WR_BURST = 3'd4
    } bseq_state_e;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_CONT  = 2'd3
    } bseq_cmd_e;

endpackage

// File: rtl/bseq_cmd_decode.sv
module bseq_cmd_decode
    import bseq_pkg::*;
(
    input  logic      adv_ld,
    input  logic      we_n,
    input  logic      sel,
    output bseq_cmd_e cmd
);

    // A continue ignores select and write; a load honours them.
    always_comb begin
        if (adv_ld)
            cmd = CMD_CONT;
        else if (!sel)
            cmd = CMD_DESEL;
        else if (!we_n)
            cmd = CMD_WRITE;
        else
            cmd = CMD_READ;
    end

endmodule

// File: rtl/bseq_fsm.sv
module bseq_fsm
    import bseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    input  bseq_cmd_e   cmd,
    output bseq_state_e state_q
);

    bseq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (cmd)
            CMD_DESEL: state_d = ST_IDLE;
            CMD_READ:  state_d = ST_RD_NEW;
            CMD_WRITE: state_d = ST_WR_NEW;
            CMD_CONT: begin
                unique case (state_q)
                    ST_RD_NEW, ST_RD_BURST: state_d = ST_RD_BURST;
                    ST_WR_NEW, ST_WR_BURST: state_d = ST_WR_BURST;
                    default:                state_d = ST_IDLE;
                endcase
            end
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (step)
            state_q <= state_d;
    end

    AST_FREEZE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q)); // R9
    AST_LOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cmd == CMD_WRITE) |=> state_q == ST_WR_NEW); // R2
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cmd == CMD_CONT && state_q == ST_IDLE) |=> state_q == ST_IDLE); // R4
    AST_WRITE_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cmd == CMD_CONT && (state_q == ST_WR_NEW || state_q == ST_WR_BURST))
        |=> state_q == ST_WR_BURST); // R3

endmodule

// File: rtl/bseq_burst_ctr.sv
module bseq_burst_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load,
    input  logic             lin_n,
    input  logic [CNT_W-1:0] ext_lo,
    output logic [CNT_W-1:0] addr_eff
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] start_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
        end else if (step) begin
            if (load) begin
                start_q <= ext_lo;
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_q + ONE;
            end
        end
    end

    // Order is a static strap, so it is applied after the registers.
    always_comb begin
        if (lin_n)
            addr_eff = start_q ^ cnt_q;
        else
            addr_eff = start_q + cnt_q;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> cnt_q == CNT_W'($past(cnt_q) + ONE)); // R6
    AST_COUNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(cnt_q) && $stable(start_q))); // R9

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import bseq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_n,
    input  logic             adv_ld,
    input  logic             we_n,
    input  logic             sel,
    input  logic             lin_n,
    input  logic [CNT_W-1:0] ext_addr_lo,
    output logic [2:0]       state,
    output logic [CNT_W-1:0] addr_lo,
    output logic             acc_valid
);

    localparam int ST_W = $bits(bseq_state_e);

    logic        step;
    bseq_cmd_e   cmd;
    bseq_state_e st;

    assign step = !clk_en_n;

    bseq_cmd_decode u_dec (
        .adv_ld (adv_ld),
        .we_n   (we_n),
        .sel    (sel),
        .cmd    (cmd)
    );

    bseq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .cmd     (cmd),
        .state_q (st)
    );

    bseq_burst_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (!adv_ld),
        .lin_n    (lin_n),
        .ext_lo   (ext_addr_lo),
        .addr_eff (addr_lo)
    );

    always_comb begin
        state     = ST_W'(st);
        acc_valid = (st != ST_IDLE);
    end

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !adv_ld) |=> addr_lo == $past(ext_addr_lo)); // R5
    AST_DROP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !adv_ld && !sel) |=> !acc_valid); // R10
    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !adv_ld && sel && we_n) |=> (acc_valid && state == 3'd1)); // R2

endmodule

// File: tb/tb_burst_seq.sv
module tb_burst_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en_n = 1'b1;
    logic       adv_ld = 1'b1;
    logic       we_n = 1'b1;
    logic       sel = 1'b0;
    logic       lin_n = 1'b0;
    logic [1:0] ext_addr_lo = 2'd0;
    logic [2:0] state;
    logic [1:0] addr_lo;
    logic       acc_valid;

    int n_run = 0;
    int n_bad = 0;
    int m_state = 0;
    int m_start = 0;
    int m_cnt = 0;

    always #5 clk = ~clk;

    burst_seq dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
        .we_n(we_n), .sel(sel), .lin_n(lin_n), .ext_addr_lo(ext_addr_lo),
        .state(state), .addr_lo(addr_lo), .acc_valid(acc_valid)
    );

    function automatic int exp_addr();
        if (lin_n) return m_start ^ m_cnt;
        return (m_start + m_cnt) % 4;
    endfunction

    task automatic compare(input string req);
        n_run += 3;
        if (int'(state) != m_state) begin
            n_bad++;
            $display("FAIL %s state actual=%0d expected=%0d", req, state, m_state);
        end
        if (int'(addr_lo) != exp_addr()) begin
            n_bad++;
            $display("FAIL %s addr_lo actual=%0d expected=%0d", req, addr_lo, exp_addr());
        end
        if (acc_valid != (m_state != 0)) begin
            n_bad++;
            $display("FAIL %s acc_valid actual=%0b expected=%0b", req, acc_valid, m_state != 0);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, update the model, check.
    task automatic cyc(input logic ce_n, input logic adv, input logic w_n,
                       input logic s, input int ea, input logic ln, input string req);
        clk_en_n = ce_n; adv_ld = adv; we_n = w_n; sel = s;
        ext_addr_lo = 2'(ea); lin_n = ln;
        @(posedge clk);
        if (!ce_n) begin
            if (!adv) begin
                m_start = ea; m_cnt = 0;
                if (!s) m_state = 0;
                else if (!w_n) m_state = 2;
                else m_state = 1;
            end else begin
                m_cnt = (m_cnt + 1) % 4;
                if (m_state == 1 || m_state == 3) m_state = 3;
                else if (m_state == 2 || m_state == 4) m_state = 4;
            end
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after release");

        // linear read burst starting at 1: 1,2,3,0 then wrap to 1
        cyc(0, 0, 1, 1, 1, 0, "R2 R5 load read");
        cyc(0, 1, 0, 0, 3, 0, "R3 R7 continue read");
        cyc(0, 1, 1, 1, 0, 0, "R3 R7 continue read");
        cyc(0, 1, 1, 0, 2, 0, "R6 R7 continue read");
        cyc(0, 1, 1, 1, 2, 0, "R6 wrap");

        // interleaved write burst starting at 2: 2,3,0,1
        cyc(0, 0, 0, 1, 2, 1, "R2 R5 load write");
        cyc(0, 1, 1, 0, 0, 1, "R3 R8 continue write");
        cyc(0, 1, 1, 1, 0, 1, "R3 R8 continue write");
        cyc(0, 1, 0, 1, 1, 1, "R8 continue write");

        // frozen edges with commands that would otherwise act
        cyc(1, 0, 1, 1, 3, 1, "R9 freeze read");
        cyc(1, 1, 0, 1, 0, 1, "R9 freeze continue");
        cyc(1, 0, 1, 0, 2, 0, "R9 freeze deselect");

        // deselect then continues from idle
        cyc(0, 0, 1, 0, 3, 0, "R2 R10 deselect");
        cyc(0, 1, 1, 1, 0, 0, "R4 R6 R10 continue idle");
        cyc(0, 1, 0, 1, 0, 1, "R4 R8 R10 continue idle");

        // back-to-back loads without dead cycles
        cyc(0, 0, 1, 1, 3, 0, "R2 read after idle");
        cyc(0, 0, 0, 1, 0, 0, "R2 write after read");
        cyc(0, 0, 1, 1, 2, 1, "R2 R5 read after write");
        cyc(0, 1, 1, 1, 0, 1, "R3 R8 read burst");

        for (int i = 0; i < 400; i++) begin
            cyc(($urandom % 5) == 0, $urandom % 2, $urandom % 2, ($urandom % 4) != 0,
                $urandom % 4, ($urandom % 8) == 0 ? ~lin_n : lin_n,
                "R2/R3/R4/R6/R7/R8/R9/R10 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule